// File: doc/BRIEF.md
# Triangle and Noise Overlay Generator for a 12-bit Converter Channel

This block sits in front of the output register of one 12-bit converter channel. It can add a generated waveform to the base code that the channel converts. There are two waveforms. One is pseudo-random noise taken from a linear feedback shift register. The other is a triangle wave that climbs from zero to a programmable peak and falls back. The generator moves forward one step per accepted trigger. The generated value is added to the base code, and a sum above the largest code clamps to full scale.

The waveform mode and the amplitude field are captured only while the channel is disabled. While the channel is enabled they stay frozen, whatever is driven on their inputs. When triggering is off, the output register copies the base code on every clock and no waveform is added. Disabling the channel freezes the output and returns the triangle to its starting point.

Top module: `tri_noise_overlay`

## Requirements
- R1: After reset, `dout` is 0. The captured mode is "off" and the captured amplitude field is 0. The triangle counter is 0 and counts upward. The noise register holds the seed 0x5A3.
- R2: While `chan_en`=1 and `trig_en`=0, `dout` takes the value of `base_val` on each rising clock edge, one cycle later, with no waveform added.
- R3: While `chan_en`=1 and `trig_en`=1, `dout` changes only on an edge where `trig`=1. On every other edge it holds its value.
- R4: Mode encoding of `wave_mode`: 2'b00 means no waveform, so a trigger loads `base_val` unchanged. 2'b01 selects noise. 2'b10 and 2'b11 both select the triangle.
- R5: Triangle mode with a captured field k (any k above 11 counts as 11): a trigger loads `base_val` plus the current counter value, then the counter steps by one. The counter reverses at the peak 2^(k+1)-1 and again at 0. With k=0 the added values run 0,1,0,1; with k=1 they run 0,1,2,3,2,1,0,1.
- R6: Noise mode: a trigger loads `base_val` plus the low k+1 bits of the 12-bit noise register (k is clamped as in R5). The register then shifts left by one. Its new bit 0 is the XOR of its old bits 11, 5, 3 and 0. The noise register moves only on triggers taken in noise mode.
- R7: When `base_val` plus the waveform value exceeds 0xFFF, `dout` becomes 0xFFF instead of wrapping.
- R8: `wave_mode` and `amp_sel` are captured on every edge where `chan_en`=0. Changes to them while `chan_en`=1 have no effect on `dout`.
- R9: While `chan_en`=0, `dout` holds its value and triggers are ignored. The triangle counter returns to 0 and counts upward, so the first trigger after re-enabling adds 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_en | input | 1 | Channel enable; 0 freezes the output and unlocks the settings |
| trig_en | input | 1 | 1: output loads only on triggers; 0: output follows the base code |
| trig | input | 1 | One-cycle trigger strobe |
| wave_mode | input | 2 | Waveform select (see R4) |
| amp_sel | input | 4 | Amplitude / noise width field k |
| base_val | input | 12 | Base code to which the waveform is added |
| dout | output | 12 | Output register value |

## Verification
The bench builds the block with its default parameters: a 12-bit data path, a 4-bit amplitude field, taps at bits 11, 5, 3 and 0, and seed 0x5A3. With a 4-bit field, codes 12 to 15 can be driven, so the clamp to a 12-bit peak is exercised. Small fields (k=0..3) keep triangle periods short enough that several reversals at both ends happen in a few dozen triggers. Base codes near 0xFFF together with peak 15 and full-width noise push the sum past full scale and exercise the clamp.

// File: rtl/tri_noise_overlay.sv
module tri_noise_overlay #(
  parameter int DW = 12,
  parameter int AW = 4,
  parameter logic [DW-1:0] TAP_MASK = 12'h829,
  parameter logic [DW-1:0] SEED = 12'h5A3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          chan_en,
  input  logic          trig_en,
  input  logic          trig,
  input  logic [1:0]    wave_mode,
  input  logic [AW-1:0] amp_sel,
  input  logic [DW-1:0] base_val,
  output logic [DW-1:0] dout
);
  localparam logic [AW-1:0] AMP_MAX = AW'(DW - 1);
  localparam logic [1:0] MODE_OFF   = 2'b00;
  localparam logic [1:0] MODE_NOISE = 2'b01;

  logic [1:0]    cfg_mode;
  logic [AW-1:0] cfg_amp;
  logic [DW-1:0] lfsr;
  logic [DW-1:0] tri_cnt;
  logic          tri_up;

  logic [AW-1:0] amp_eff;
  logic [AW:0]   span;
  logic [DW-1:0] wmask;
  logic [DW-1:0] wave;
  logic [DW:0]   sum;
  logic [DW-1:0] sat;
  logic          fire;
  logic          lfsr_fb;

  assign fire    = chan_en & trig_en & trig;
  assign amp_eff = (cfg_amp > AMP_MAX) ? AMP_MAX : cfg_amp;
  assign span    = {1'b0, amp_eff} + (AW+1)'(1);
  assign wmask   = ~({DW{1'b1}} << span);
  assign lfsr_fb = ^(lfsr & TAP_MASK);

  always_comb begin
    case (cfg_mode)
      MODE_OFF:   wave = '0;
      MODE_NOISE: wave = lfsr & wmask;
      default:    wave = tri_cnt;
    endcase
  end

  assign sum = {1'b0, base_val} + {1'b0, wave};
  assign sat = sum[DW] ? {DW{1'b1}} : sum[DW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_mode <= MODE_OFF;
      cfg_amp  <= '0;
    end else if (!chan_en) begin
      cfg_mode <= wave_mode;
      cfg_amp  <= amp_sel;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      lfsr <= SEED;
    else if (fire && cfg_mode == MODE_NOISE)
      lfsr <= {lfsr[DW-2:0], lfsr_fb};
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !chan_en) begin
      tri_cnt <= '0;
      tri_up  <= 1'b1;
    end else if (fire && cfg_mode[1]) begin
      if (tri_up) begin
        if (tri_cnt == wmask) begin
          tri_up  <= 1'b0;
          tri_cnt <= tri_cnt - 1'b1;
        end else begin
          tri_cnt <= tri_cnt + 1'b1;
        end
      end else begin
        if (tri_cnt == '0) begin
          tri_up  <= 1'b1;
          tri_cnt <= tri_cnt + 1'b1;
        end else begin
          tri_cnt <= tri_cnt - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      dout <= '0;
    else if (chan_en) begin
      if (!trig_en)
        dout <= base_val;
      else if (trig)
        dout <= sat;
    end
  end
endmodule

// File: rtl/tri_noise_overlay_chk.sv
module tri_noise_overlay_chk #(
  parameter int DW = 12,
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          chan_en,
  input logic          trig_en,
  input logic          trig,
  input logic [DW-1:0] base_val,
  input logic [DW-1:0] dout,
  input logic [1:0]    cfg_mode,
  input logic [AW-1:0] cfg_amp,
  input logic [DW-1:0] tri_cnt
);
  logic [DW-1:0] peak;
  always_comb begin
    peak = '0;
    for (int i = 0; i < DW; i++)
      if (i <= int'(cfg_amp)) peak[i] = 1'b1;
  end

  a_r2_follow_base: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_en && !trig_en) |=> dout == $past(base_val));

  a_r3_hold_no_trig: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_en && trig_en && !trig) |=> $stable(dout));

  a_r4_off_passes_base: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_en && trig_en && trig && cfg_mode == 2'b00) |=> dout == $past(base_val));

  a_r5_tri_bound: assert property (@(posedge clk) disable iff (!rst_n)
    tri_cnt <= peak);

  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_en && trig_en && trig) |=> dout >= $past(base_val));

  a_r8_cfg_locked: assert property (@(posedge clk) disable iff (!rst_n)
    chan_en |=> ($stable(cfg_mode) && $stable(cfg_amp)));

  a_r9_frozen_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_en |=> ($stable(dout) && tri_cnt == '0));
endmodule

bind tri_noise_overlay tri_noise_overlay_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .trig_en(trig_en), .trig(trig),
  .base_val(base_val), .dout(dout), .cfg_mode(cfg_mode), .cfg_amp(cfg_amp),
  .tri_cnt(tri_cnt)
);

// File: tb/tb_tri_noise_overlay.sv
`timescale 1ns/1ps
module tb_tri_noise_overlay;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        chan_en = 1'b0, trig_en = 1'b0, trig = 1'b0;
  logic [1:0]  wave_mode = 2'b00;
  logic [3:0]  amp_sel = 4'd0;
  logic [11:0] base_val = 12'd0;
  logic [11:0] dout;

  int n_chk = 0, n_bad = 0;

  // reference state
  logic [11:0] m_lfsr, m_cnt, m_dout;
  logic        m_up;
  logic [1:0]  m_mode;
  logic [3:0]  m_amp;

  tri_noise_overlay dut (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .trig_en(trig_en), .trig(trig),
    .wave_mode(wave_mode), .amp_sel(amp_sel), .base_val(base_val), .dout(dout)
  );

  always #10 clk = ~clk;

  initial begin
    #(20 * 20000);
    n_bad++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  task automatic chk(input string tag, input logic [11:0] act, input logic [11:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %03h expected %03h", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] peak_of(input logic [3:0] k);
    int kk = (k > 4'd11) ? 11 : int'(k);
    return 12'((1 << (kk + 1)) - 1);
  endfunction

  task automatic cyc(input logic en, input logic te, input logic tr,
                     input logic [1:0] md, input logic [3:0] am,
                     input logic [11:0] bv, input string tag);
    logic [11:0] w, pk, n_cnt, n_lfsr, n_dout;
    logic        n_up;
    int          s;
    chan_en = en; trig_en = te; trig = tr; wave_mode = md; amp_sel = am; base_val = bv;
    @(posedge clk);
    pk = peak_of(m_amp);
    n_cnt = m_cnt; n_up = m_up; n_lfsr = m_lfsr; n_dout = m_dout;
    if (en) begin
      if (!te) n_dout = bv;
      else if (tr) begin
        if (m_mode == 2'b01) w = m_lfsr & pk;
        else if (m_mode[1]) w = m_cnt;
        else w = 12'd0;
        s = int'(bv) + int'(w);
        n_dout = (s > 4095) ? 12'hFFF : 12'(s);
        if (m_mode == 2'b01)
          n_lfsr = {m_lfsr[10:0], m_lfsr[11] ^ m_lfsr[5] ^ m_lfsr[3] ^ m_lfsr[0]};
        if (m_mode[1]) begin
          if (m_up && m_cnt == pk) begin n_up = 1'b0; n_cnt = m_cnt - 1; end
          else if (!m_up && m_cnt == 0) begin n_up = 1'b1; n_cnt = m_cnt + 1; end
          else n_cnt = m_up ? m_cnt + 1 : m_cnt - 1;
        end
      end
    end else begin
      m_mode = md; m_amp = am; n_cnt = 12'd0; n_up = 1'b1;
    end
    m_cnt = n_cnt; m_up = n_up; m_lfsr = n_lfsr; m_dout = n_dout;
    @(negedge clk);
    chk(tag, dout, m_dout);
  endtask

  task automatic t_reset_r1();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    m_lfsr = 12'h5A3; m_cnt = 0; m_up = 1'b1; m_mode = 2'b00; m_amp = 4'd0; m_dout = 12'd0;
    @(negedge clk);
    chk("R1 reset dout", dout, 12'h000);
    // first noise sample after reset shows the seed's low bits (k=11: full seed)
    cyc(0, 1, 0, 2'b01, 4'd11, 12'h000, "R1 cfg");
    cyc(1, 1, 1, 2'b01, 4'd11, 12'h000, "R1 seed");
    chk("R1 seed value", dout, 12'h5A3);
    cyc(0, 1, 0, 2'b00, 4'd0, 12'h000, "R1 idle");
  endtask

  task automatic t_direct_r2();
    cyc(0, 0, 0, 2'b10, 4'd3, 12'h000, "R2 cfg");
    cyc(1, 0, 0, 2'b10, 4'd3, 12'h123, "R2 follow");
    chk("R2 explicit", dout, 12'h123);
    cyc(1, 0, 1, 2'b10, 4'd3, 12'hABC, "R2 follow trig");
    cyc(1, 0, 0, 2'b10, 4'd3, 12'hFFF, "R2 follow max");
    cyc(1, 0, 0, 2'b10, 4'd3, 12'h000, "R2 follow zero");
  endtask

  task automatic t_hold_r3_r4();
    cyc(0, 1, 0, 2'b00, 4'd0, 12'h000, "R4 cfg");
    cyc(1, 1, 0, 2'b00, 4'd0, 12'h111, "R3 hold");
    cyc(1, 1, 0, 2'b00, 4'd0, 12'h222, "R3 hold");
    cyc(1, 1, 1, 2'b00, 4'd0, 12'h345, "R4 off load");
    chk("R4 off explicit", dout, 12'h345);
    cyc(1, 1, 0, 2'b00, 4'd0, 12'h999, "R3 hold after");
    chk("R3 hold explicit", dout, 12'h345);
    cyc(1, 1, 1, 2'b00, 4'd0, 12'hFFE, "R4 off load2");
  endtask

  task automatic t_triangle_r5();
    cyc(0, 1, 0, 2'b10, 4'd0, 12'h100, "R5 cfg k0");
    for (int i = 0; i < 6; i++) begin
      cyc(1, 1, 1, 2'b10, 4'd0, 12'h100, "R5 k0");
      chk("R5 k0 explicit", dout, (i % 2 == 0) ? 12'h100 : 12'h101);
    end
    cyc(0, 1, 0, 2'b11, 4'd1, 12'h200, "R5 cfg k1 mode3");
    for (int i = 0; i < 12; i++) begin
      cyc(1, 1, 1, 2'b11, 4'd1, 12'h200, "R5 k1");
      cyc(1, 1, 0, 2'b11, 4'd1, 12'h300, "R5 k1 gap");
    end
    cyc(0, 1, 0, 2'b10, 4'd2, 12'h040, "R5 cfg k2");
    for (int i = 0; i < 20; i++) cyc(1, 1, 1, 2'b10, 4'd2, 12'h040, "R5 k2");
    cyc(0, 1, 0, 2'b10, 4'd15, 12'h000, "R5 cfg clamp");
    for (int i = 0; i < 6; i++) cyc(1, 1, 1, 2'b10, 4'd15, 12'h000, "R5 clamp");
  endtask

  task automatic t_noise_r6();
    cyc(0, 1, 0, 2'b01, 4'd0, 12'h000, "R6 cfg k0");
    for (int i = 0; i < 8; i++) cyc(1, 1, 1, 2'b01, 4'd0, 12'h010, "R6 k0");
    cyc(0, 1, 0, 2'b01, 4'd3, 12'h000, "R6 cfg k3");
    for (int i = 0; i < 8; i++) cyc(1, 1, 1, 2'b01, 4'd3, 12'h020, "R6 k3");
    cyc(0, 1, 0, 2'b01, 4'd11, 12'h000, "R6 cfg k11");
    for (int i = 0; i < 8; i++) begin
      cyc(1, 1, 1, 2'b01, 4'd11, 12'h000, "R6 k11");
      cyc(1, 1, 0, 2'b01, 4'd11, 12'h000, "R6 k11 gap");
    end
  endtask

  task automatic t_sat_r7();
    cyc(0, 1, 0, 2'b10, 4'd3, 12'h000, "R7 cfg tri");
    for (int i = 0; i < 20; i++) cyc(1, 1, 1, 2'b10, 4'd3, 12'hFF8, "R7 tri");
    cyc(0, 1, 0, 2'b10, 4'd3, 12'h000, "R7 cfg tri2");
    for (int i = 0; i < 9; i++) cyc(1, 1, 1, 2'b10, 4'd3, 12'hFFA, "R7 tri2");
    chk("R7 saturated explicit", dout, 12'hFFF);
    cyc(0, 1, 0, 2'b01, 4'd11, 12'h000, "R7 cfg noise");
    for (int i = 0; i < 10; i++) cyc(1, 1, 1, 2'b01, 4'd11, 12'hF00, "R7 noise");
  endtask

  task automatic t_lock_r8();
    cyc(0, 1, 0, 2'b10, 4'd1, 12'h000, "R8 cfg");
    for (int i = 0; i < 10; i++)
      cyc(1, 1, 1, (i % 2) ? 2'b01 : 2'b00, 4'd7, 12'h500, "R8 locked");
    cyc(0, 1, 0, 2'b00, 4'd7, 12'h000, "R8 unlock");
    cyc(1, 1, 1, 2'b10, 4'd1, 12'h777, "R8 new cfg off");
    chk("R8 new mode explicit", dout, 12'h777);
  endtask

  task automatic t_disable_r9();
    cyc(0, 1, 0, 2'b10, 4'd2, 12'h000, "R9 cfg");
    for (int i = 0; i < 3; i++) cyc(1, 1, 1, 2'b10, 4'd2, 12'h080, "R9 run");
    cyc(0, 1, 1, 2'b10, 4'd2, 12'h3C3, "R9 off trig");
    chk("R9 held explicit", dout, 12'h082);
    cyc(0, 0, 0, 2'b10, 4'd2, 12'h111, "R9 off notrig");
    cyc(1, 1, 1, 2'b10, 4'd2, 12'h080, "R9 restart");
    chk("R9 restart explicit", dout, 12'h080);
    cyc(1, 1, 1, 2'b10, 4'd2, 12'h080, "R9 restart2");
  endtask

  initial begin
    t_reset_r1();
    t_direct_r2();
    t_hold_r3_r4();
    t_triangle_r5();
    t_noise_r6();
    t_sat_r7();
    t_lock_r8();
    t_disable_r9();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule